// File: doc/BRIEF.md
# XOR Sprite Blitter with Collision Detect

The blitter composites a monochrome sprite onto a 64 by 32 frame buffer holding one bit per pixel. A sprite is a stack of 1 to 15 rows. Each row is one byte fetched from a byte-wide memory, beginning at a caller-supplied sprite address. Every sprite bit is combined with the pixel under it by exclusive-OR. Drawing the same sprite twice therefore erases it. A collision flag records whether any lit pixel was switched off during the draw. A second command blanks the whole frame buffer.

The frame buffer and the sprite memory both sit outside the block. Each is reached through a simple port with a one-cycle read latency. The block handles one pixel at a time: it reads the pixel in one cycle and writes it back in the next. The caller issues a command through a start strobe. It then waits for the one-cycle done pulse, after which the collision output is valid.

Top module: `sprite_blitter`

## Requirements
- R1: The frame-buffer address of the pixel in column c and row r is r*64 + c, with the row in the upper 5 bits of `fb_addr` and the column in the lower 6 bits.
- R2: When drawing n rows, the block reads sprite bytes at `spr_addr`+0, +1, … up to +(n-1), in that order, one read per row. The 12-bit address wraps from 4095 to 0.
- R3: Within a sprite byte, bit 7 maps to column X and bit 0 maps to column X+7.
- R4: Pixel column k of row j lands at column (X+k) mod 64 and row (Y+j) mod 32. Each pixel wraps on its own; nothing is clipped.
- R5: Each sprite pixel replaces its frame-buffer pixel with sprite bit XOR old pixel. Pixels outside the sprite are left unchanged.
- R6: `collision` is cleared when a draw is accepted. It is 1 after the draw exactly when some sprite bit of 1 met a frame-buffer pixel of 1.
- R7: The clear command writes 0 to each of the 2048 pixels exactly once and touches nothing else.
- R8: Each sprite pixel costs one read of its frame-buffer address, followed in the next cycle by one write to the same address. A draw of n rows therefore makes exactly 8n writes.
- R9: `busy` stays high from the cycle after a start is accepted until the operation ends. `done` is then high for one cycle with `busy` low.
- R10: A draw with zero rows raises `done` in the cycle after the start is accepted. It writes no pixel and leaves `collision` at 0.
- R11: A `start` that arrives while `busy` is high has no effect on the running operation or its result.
- R12: After reset, `busy`, `done`, `collision`, `mem_rd`, `fb_rd` and `fb_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, accepted only while idle |
| cmd_clear | input | 1 | 1 selects blanking the buffer, 0 selects a sprite draw |
| org_x | input | 6 | Sprite origin column |
| org_y | input | 5 | Sprite origin row |
| n_rows | input | 4 | Sprite height in rows (0 to 15) |
| spr_addr | input | 12 | Address of the first sprite byte |
| mem_rd | output | 1 | Sprite memory read strobe |
| mem_addr | output | 12 | Sprite memory address |
| mem_rdata | input | 8 | Sprite byte, valid the cycle after `mem_rd` |
| fb_rd | output | 1 | Frame-buffer read strobe |
| fb_we | output | 1 | Frame-buffer write strobe |
| fb_addr | output | 11 | Frame-buffer pixel address (row*64 + column) |
| fb_rdata | input | 1 | Pixel value, valid the cycle after `fb_rd` |
| fb_wdata | output | 1 | Pixel value to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| collision | output | 1 | A lit pixel was turned off by the last draw |

## Verification
Some rules hold on every cycle, and the in-RTL assertions check those. They cover the pairing of each draw write with a read of the same address in the previous cycle, and the rule that the read and write strobes never overlap. They also check that blanking writes only zeros, that the collision flag only falls when a draw is accepted, and that the request stays frozen against a start arriving while busy. Finally, they check that done comes only while idle, and that every exit from busy is marked by done.

The pixel placement itself can only be shown by the bench's scenarios. This covers bit order, wrap-around in both axes and the XOR result. The bench compares the whole frame buffer against an arithmetic model after each draw, sweeping every origin column and every row count. The same applies to the end-to-end value of the collision flag, the erase-by-redraw behaviour, and the exact latency of a zero-row draw.

// File: rtl/blit_pkg.sv
package blit_pkg;

    // Pixels per sprite row (one byte)
    localparam int PIX_W = 8;
    localparam int COL_W = $clog2(PIX_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,   // sprite byte read issued
        ST_LOAD,    // sprite byte arrives
        ST_PRD,     // frame-buffer pixel read issued
        ST_PWR,     // pixel written back
        ST_CLR      // blanking sweep
    } blit_state_e;

    typedef struct packed {
        logic wbit;  // new pixel value
        logic hit;   // lit pixel switched off
    } pix_res_t;

    // Pick the sprite bit for a column; leftmost pixel is the MSB
    function automatic logic sprite_bit(input logic [PIX_W-1:0] row_byte,
                                        input logic [COL_W-1:0] col);
        logic [COL_W-1:0] sel;
        sel = COL_W'(PIX_W - 1) - col;
        return row_byte[sel];
    endfunction

endpackage

// File: rtl/blit_seq.sv
module blit_seq
    import blit_pkg::*;
#(
    parameter int FB_W  = 64,
    parameter int FB_H  = 32,
    parameter int CNT_W = 4,
    localparam int FBA_W = $clog2(FB_W) + $clog2(FB_H)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_draw,
    input  logic              go_clear,
    input  logic [CNT_W-1:0]  n_rows,
    output blit_state_e       state,
    output logic [CNT_W-1:0]  row_idx,
    output logic [COL_W-1:0]  col_idx,
    output logic [FBA_W-1:0]  clr_idx,
    output logic              done
);

    localparam logic [FBA_W-1:0] LAST_PIX = FBA_W'(FB_W * FB_H - 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(PIX_W - 1);

    logic [CNT_W-1:0] rows_q;
    logic             last_row;

    assign last_row = ({1'b0, row_idx} + 1'b1) == {1'b0, rows_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            row_idx <= '0;
            col_idx <= '0;
            clr_idx <= '0;
            rows_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (go_clear) begin
                        state   <= ST_CLR;
                        clr_idx <= '0;
                    end else if (go_draw) begin
                        if (n_rows == '0) begin
                            done <= 1'b1;
                        end else begin
                            state   <= ST_FETCH;
                            rows_q  <= n_rows;
                            row_idx <= '0;
                            col_idx <= '0;
                        end
                    end
                end
                ST_FETCH: state <= ST_LOAD;
                ST_LOAD: begin
                    state   <= ST_PRD;
                    col_idx <= '0;
                end
                ST_PRD: state <= ST_PWR;
                ST_PWR: begin
                    if (col_idx == LAST_COL) begin
                        if (last_row) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            row_idx <= row_idx + 1'b1;
                            state   <= ST_FETCH;
                        end
                    end else begin
                        col_idx <= col_idx + 1'b1;
                        state   <= ST_PRD;
                    end
                end
                ST_CLR: begin
                    if (clr_idx == LAST_PIX) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        clr_idx <= clr_idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: completion is only signalled from the idle state
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> state == ST_IDLE);

    // R2: the row counter never runs past the latched height
    assert_row_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (state inside {ST_FETCH, ST_LOAD, ST_PRD, ST_PWR}) |-> row_idx < rows_q);

endmodule

// File: rtl/blit_pix.sv
module blit_pix
    import blit_pkg::*;
#(
    parameter int FB_W  = 64,
    parameter int FB_H  = 32,
    parameter int CNT_W = 4,
    localparam int XW    = $clog2(FB_W),
    localparam int YW    = $clog2(FB_H),
    localparam int FBA_W = XW + YW
) (
    input  logic [XW-1:0]    ox,
    input  logic [YW-1:0]    oy,
    input  logic [CNT_W-1:0] row_idx,
    input  logic [COL_W-1:0] col_idx,
    input  logic [PIX_W-1:0] row_byte,
    input  logic             dst_bit,
    output logic [FBA_W-1:0] fb_idx,
    output pix_res_t         res
);

    logic [XW-1:0] px;
    logic [YW-1:0] py;
    logic          src;

    // Power-of-two sizes make the modulo a plain truncation
    assign px     = ox + XW'(col_idx);
    assign py     = oy + YW'(row_idx);
    assign fb_idx = {py, px};

    assign src      = sprite_bit(row_byte, col_idx);
    assign res.wbit = src ^ dst_bit;
    assign res.hit  = src & dst_bit;

endmodule

// File: rtl/sprite_blitter.sv
module sprite_blitter
    import blit_pkg::*;
#(
    parameter int FB_W   = 64,
    parameter int FB_H   = 32,
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 4,
    localparam int XW    = $clog2(FB_W),
    localparam int YW    = $clog2(FB_H),
    localparam int FBA_W = XW + YW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cmd_clear,
    input  logic [XW-1:0]     org_x,
    input  logic [YW-1:0]     org_y,
    input  logic [CNT_W-1:0]  n_rows,
    input  logic [ADDR_W-1:0] spr_addr,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [PIX_W-1:0]  mem_rdata,
    output logic              fb_rd,
    output logic              fb_we,
    output logic [FBA_W-1:0]  fb_addr,
    input  logic              fb_rdata,
    output logic              fb_wdata,
    output logic              busy,
    output logic              done,
    output logic              collision
);

    blit_state_e       state;
    logic [CNT_W-1:0]  row_idx;
    logic [COL_W-1:0]  col_idx;
    logic [FBA_W-1:0]  clr_idx;
    logic [FBA_W-1:0]  pix_idx;
    pix_res_t          pres;

    logic              idle;
    logic              go_draw;
    logic              go_clear;

    logic [XW-1:0]     ox_q;
    logic [YW-1:0]     oy_q;
    logic [ADDR_W-1:0] base_q;
    logic [PIX_W-1:0]  byte_q;
    logic              coll_q;

    assign idle     = (state == ST_IDLE);
    assign go_draw  = idle && start && !cmd_clear;
    assign go_clear = idle && start && cmd_clear;

    blit_seq #(
        .FB_W  (FB_W),
        .FB_H  (FB_H),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .go_draw  (go_draw),
        .go_clear (go_clear),
        .n_rows   (n_rows),
        .state    (state),
        .row_idx  (row_idx),
        .col_idx  (col_idx),
        .clr_idx  (clr_idx),
        .done     (done)
    );

    blit_pix #(
        .FB_W  (FB_W),
        .FB_H  (FB_H),
        .CNT_W (CNT_W)
    ) u_pix (
        .ox       (ox_q),
        .oy       (oy_q),
        .row_idx  (row_idx),
        .col_idx  (col_idx),
        .row_byte (byte_q),
        .dst_bit  (fb_rdata),
        .fb_idx   (pix_idx),
        .res      (pres)
    );

    // Request capture and collision accumulation
    always_ff @(posedge clk) begin
        if (rst) begin
            ox_q   <= '0;
            oy_q   <= '0;
            base_q <= '0;
            byte_q <= '0;
            coll_q <= 1'b0;
        end else begin
            if (go_draw) begin
                ox_q   <= org_x;
                oy_q   <= org_y;
                base_q <= spr_addr;
                coll_q <= 1'b0;
            end
            if (state == ST_LOAD) begin
                byte_q <= mem_rdata;
            end
            if (state == ST_PWR && pres.hit) begin
                coll_q <= 1'b1;
            end
        end
    end

    always_comb begin
        mem_rd   = (state == ST_FETCH);
        mem_addr = base_q + ADDR_W'(row_idx);
        fb_rd    = (state == ST_PRD);
        fb_we    = (state == ST_PWR) || (state == ST_CLR);
        fb_addr  = (state == ST_CLR) ? clr_idx : pix_idx;
        fb_wdata = (state == ST_CLR) ? 1'b0 : pres.wbit;
    end

    assign busy      = !idle;
    assign collision = coll_q;

    // R8: read and write strobes never share a cycle
    assert_no_rw_overlap_R8: assert property (@(posedge clk) disable iff (rst)
        !(fb_rd && fb_we));

    // R8: a draw write follows a read of the same pixel
    assert_rw_pair_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PWR) |-> ($past(fb_rd) && $past(fb_addr) == fb_addr));

    // R7: a write with no preceding read is a blanking write of zero
    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (fb_we && !$past(fb_rd)) |-> !fb_wdata);

    // R6: the flag falls only when a draw has just been accepted
    assert_coll_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(collision) |-> $past(start && !busy && !cmd_clear));

    // R9: done and busy are exclusive, and leaving busy raises done
    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    assert_busy_exit_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R11: a start while busy leaves the captured request alone
    assert_ignore_start_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(ox_q) && $stable(oy_q) && $stable(base_q)));

    // R2: sprite reads only happen inside a draw
    assert_mem_in_op_R2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> busy);

endmodule

// File: tb/sprite_blitter_tb.sv
module sprite_blitter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NPIX       = 2048;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        cmd_clear;
    logic [5:0]  org_x;
    logic [4:0]  org_y;
    logic [3:0]  n_rows;
    logic [11:0] spr_addr;
    logic        mem_rd;
    logic [11:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        fb_rd;
    logic        fb_we;
    logic [10:0] fb_addr;
    logic        fb_rdata;
    logic        fb_wdata;
    logic        busy;
    logic        done;
    logic        collision;

    always #(CLK_PERIOD/2) clk = ~clk;

    sprite_blitter u_dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd_clear (cmd_clear),
        .org_x     (org_x),
        .org_y     (org_y),
        .n_rows    (n_rows),
        .spr_addr  (spr_addr),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .fb_rd     (fb_rd),
        .fb_we     (fb_we),
        .fb_addr   (fb_addr),
        .fb_rdata  (fb_rdata),
        .fb_wdata  (fb_wdata),
        .busy      (busy),
        .done      (done),
        .collision (collision)
    );

    // Memory models
    logic [7:0] smem [0:4095];
    logic [7:0] mem_q;
    logic       fb_mem [0:NPIX-1];
    logic       fb_q;
    logic       fb_fill;
    logic       exp_fb [0:NPIX-1];

    always @(posedge clk) begin
        if (mem_rd) mem_q <= smem[mem_addr];
        if (fb_rd)  fb_q  <= fb_mem[fb_addr];
        if (fb_fill) begin
            for (int i = 0; i < NPIX; i++) fb_mem[i] <= 1'b1;
        end else if (fb_we) begin
            fb_mem[fb_addr] <= fb_wdata;
        end
    end
    assign mem_rdata = mem_q;
    assign fb_rdata  = fb_q;

    // Port monitor
    logic [11:0] cur_base;
    logic        cur_clear;
    logic [11:0] rd_idx;
    int          bad_rd;
    int          bad_seq;
    int          wr_cnt;
    logic        prev_rd;
    logic [10:0] prev_addr;

    always @(posedge clk) begin
        if (rst) begin
            rd_idx  <= '0;
            bad_rd  <= 0;
            bad_seq <= 0;
            wr_cnt  <= 0;
            prev_rd <= 1'b0;
            prev_addr <= '0;
        end else begin
            if (start && !busy) begin
                rd_idx <= '0;
            end else if (mem_rd) begin
                if (mem_addr != cur_base + rd_idx) bad_rd <= bad_rd + 1;
                rd_idx <= rd_idx + 1'b1;
            end
            if (fb_we) begin
                wr_cnt <= wr_cnt + 1;
                if (!cur_clear && !(prev_rd && prev_addr == fb_addr))
                    bad_seq <= bad_seq + 1;
            end
            prev_rd   <= fb_rd;
            prev_addr <= fb_addr;
        end
    end

    int checks   = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Arithmetic reference for a draw
    task automatic model_draw(input int x, input int y, input int n,
                              input int base, output bit c);
        c = 1'b0;
        for (int r = 0; r < n; r++) begin
            logic [7:0] b;
            b = smem[(base + r) % 4096];
            for (int k = 0; k < 8; k++) begin
                int a;
                bit s;
                s = b[7-k];
                a = ((y + r) % 32) * 64 + ((x + k) % 64);
                if (s && exp_fb[a]) c = 1'b1;
                exp_fb[a] = exp_fb[a] ^ s;
            end
        end
    endtask

    task automatic compare_fb(input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < NPIX; i++) if (fb_mem[i] !== exp_fb[i]) bad++;
        chk(bad == 0, req, "frame buffer mismatching pixels", bad, 0);
    endtask

    // Issue one command and wait for done; optional stray start at cycle stall_at
    task automatic run_op(input bit clr, input int x, input int y, input int n,
                          input int base, input int stall_at,
                          output int wrs, output int lat);
        int w0;
        int gaps;
        cur_clear = clr;
        cur_base  = base[11:0];
        w0 = wr_cnt;
        @(negedge clk);
        start = 1'b1; cmd_clear = clr;
        org_x = x[5:0]; org_y = y[4:0]; n_rows = n[3:0]; spr_addr = base[11:0];
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        gaps = 0;
        while (!done && lat < 5000) begin
            if (!busy) gaps++;
            if (lat == stall_at) begin
                start = 1'b1; cmd_clear = 1'b1;
                org_x = 6'd0; org_y = 5'd0; n_rows = 4'd3; spr_addr = 12'h0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk(done === 1'b1, "R9", "done reached", int'(done), 1);
        chk(gaps == 0, "R9", "busy low before done", gaps, 0);
        chk(busy === 1'b0, "R9", "busy during done", int'(busy), 0);
        @(negedge clk);
        chk(done === 1'b0, "R9", "done width", int'(done), 0);
        wrs = wr_cnt - w0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        int  wrs;
        int  lat;
        bit  c;

        for (int i = 0; i < 4096; i++) smem[i] = 8'((i * 29 + 7) ^ (i >> 2));
        smem[12'h300] = 8'h80;
        smem[12'h301] = 8'h01;
        smem[12'h310] = 8'hA5;
        smem[12'h500] = 8'hFF;
        for (int i = 0; i < NPIX; i++) exp_fb[i] = 1'b1;

        rst = 1'b1; fb_fill = 1'b1; start = 1'b0; cmd_clear = 1'b0;
        org_x = '0; org_y = '0; n_rows = '0; spr_addr = '0;
        cur_base = '0; cur_clear = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0; fb_fill = 1'b0;
        @(negedge clk);

        // R12: reset state
        chk(busy === 1'b0, "R12", "busy after reset", int'(busy), 0);
        chk(done === 1'b0, "R12", "done after reset", int'(done), 0);
        chk(collision === 1'b0, "R12", "collision after reset", int'(collision), 0);
        chk({mem_rd, fb_rd, fb_we} === 3'b000, "R12", "strobes after reset",
            int'({mem_rd, fb_rd, fb_we}), 0);

        // R7: blank the all-ones buffer
        run_op(1'b1, 0, 0, 0, 0, -1, wrs, lat);
        chk(wrs == NPIX, "R7", "clear write count", wrs, NPIX);
        for (int i = 0; i < NPIX; i++) exp_fb[i] = 1'b0;
        compare_fb("R7");

        // R1/R3: single pixels
        model_draw(5, 3, 1, 12'h300, c);
        run_op(1'b0, 5, 3, 1, 12'h300, -1, wrs, lat);
        chk(fb_mem[3*64+5] === 1'b1, "R1", "pixel at row 3 col 5", int'(fb_mem[3*64+5]), 1);
        compare_fb("R1");
        model_draw(5, 4, 1, 12'h301, c);
        run_op(1'b0, 5, 4, 1, 12'h301, -1, wrs, lat);
        chk(fb_mem[4*64+12] === 1'b1, "R3", "bit 0 at col X+7", int'(fb_mem[4*64+12]), 1);
        compare_fb("R3");

        // R4: every origin column, one row
        for (int x = 0; x < 64; x++) begin
            int y;
            int base;
            y = (x * 7) % 32;
            base = 12'h310 + (x % 4);
            model_draw(x, y, 1, base, c);
            run_op(1'b0, x, y, 1, base, -1, wrs, lat);
            compare_fb("R4");
            chk(collision === c, "R6", "collision on column sweep", int'(collision), int'(c));
            chk(wrs == 8, "R8", "writes for one row", wrs, 8);
        end

        // R2/R5: every row count with wrap in both axes and address wrap
        for (int n = 1; n < 16; n++) begin
            int x;
            int y;
            int base;
            x = (n * 13) % 64;
            y = (n * 5 + 20) % 32;
            base = (n == 15) ? 12'hFFA : (12'h400 + n * 16);
            model_draw(x, y, n, base, c);
            run_op(1'b0, x, y, n, base, -1, wrs, lat);
            compare_fb("R5");
            chk(collision === c, "R6", "collision on row sweep", int'(collision), int'(c));
            chk(wrs == 8 * n, "R8", "writes per draw", wrs, 8 * n);
        end

        // R6: redraw erases and reports collision
        model_draw(10, 10, 6, 12'h500, c);
        run_op(1'b0, 10, 10, 6, 12'h500, -1, wrs, lat);
        model_draw(10, 10, 6, 12'h500, c);
        run_op(1'b0, 10, 10, 6, 12'h500, -1, wrs, lat);
        chk(collision === 1'b1, "R6", "redraw collision", int'(collision), 1);
        compare_fb("R6");

        // R10: zero-row draw after a collision
        run_op(1'b0, 20, 20, 0, 12'h500, -1, wrs, lat);
        chk(lat == 1, "R10", "zero-row latency", lat, 1);
        chk(collision === 1'b0, "R10", "zero-row collision", int'(collision), 0);
        chk(wrs == 0, "R10", "zero-row writes", wrs, 0);
        compare_fb("R10");

        // R11: stray clear request mid-draw is ignored
        model_draw(30, 28, 10, 12'h600, c);
        run_op(1'b0, 30, 28, 10, 12'h600, 3, wrs, lat);
        chk(wrs == 80, "R11", "writes with stray start", wrs, 80);
        chk(collision === c, "R11", "collision with stray start", int'(collision), int'(c));
        compare_fb("R11");

        chk(bad_rd == 0, "R2", "out-of-order sprite reads", bad_rd, 0);
        chk(bad_seq == 0, "R8", "writes without paired read", bad_seq, 0);

        summary();
        $finish;
    end

endmodule